// File: doc/BRIEF.md
# DRAM Bank Access Sequencer

This block steps a single dynamic memory bank through the full cell-access cycle. Each access runs from one request to the end of its write-back. The host sends the address over one shared address port in two beats. The row half comes first and is qualified by a row strobe. The column half follows, qualified by a column strobe, together with the write flag and the write data.

Once the column beat is accepted, the sequencer runs five phases in order:

- bit-line precharge;
- word-line activation, which moves the whole row into a row buffer that stands in for the sense amplifiers;
- sensing;
- a single column-access cycle, which delivers a read word or forces the written word into the buffer;
- a restore phase, which writes the whole buffer back into the array.

Opening a row clears it in the array, so a read destroys the stored row. Only the restore phase puts the data back. Every phase drives its own control strobe, and the phase lengths are parameters. The bank array is synthesizable and holds ROWS rows of COLS words each.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset the sequencer is idle. prech_en is 1, and wordline_en, sense_en, col_sel_en, restore_en, rd_valid and busy are 0. req_ready is 1, and every stored word reads back as 0.
- R2: In idle with req_ready high, a row_stb cycle latches the row from addr. The next col_stb cycle latches the column from addr, plus wr_en and wr_data, and starts the access. A col_stb with no row latched is ignored, and so is a second row_stb while a row is already latched.
- R3: For TPRE cycles after the column beat is accepted, prech_en stays high and wordline_en stays low. prech_en is never high in the same cycle as wordline_en.
- R4: After precharge, wordline_en is high alone for TACT cycles. sense_en then rises and stays high for TSENSE cycles. sense_en is only ever high while wordline_en is high.
- R5: The cycle after sensing is a single column cycle with col_sel_en high, alongside wordline_en and sense_en.
- R6: For a read, rd_valid is a one-cycle pulse in the column cycle, and rd_data then carries the word stored at the latched row and column.
- R7: After the column cycle, restore_en is high for TRESTORE cycles and the row is written back. A second read of the same location returns the same word.
- R8: A write replaces only the addressed word. The other words of that row keep their values, and a write raises no rd_valid.
- R9: busy is high, and req_ready low, from the cycle after the column beat for TPRE+TACT+TSENSE+1+TRESTORE cycles. Strobes that arrive while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | max(log2 ROWS, log2 COLS) | Shared address port: row half, then column half |
| row_stb | input | 1 | Qualifies the row half on addr |
| col_stb | input | 1 | Qualifies the column half, wr_en and wr_data |
| wr_en | input | 1 | 1 = write access, 0 = read access |
| wr_data | input | DW | Word to write |
| req_ready | output | 1 | High when a strobe can be taken |
| busy | output | 1 | Access in progress, from accept through restore |
| prech_en | output | 1 | Bit-line precharge strobe |
| wordline_en | output | 1 | Word-line strobe for the latched row |
| sense_en | output | 1 | Sense-amplifier enable |
| col_sel_en | output | 1 | Column access strobe |
| restore_en | output | 1 | Row write-back strobe |
| rd_valid | output | 1 | One-cycle read-data valid pulse |
| rd_data | output | DW | Read word |

## Verification
Count cycles from the clock edge that accepts the column beat, taken as cycle 1. Precharge then covers cycles 1 to TPRE, and the word line rises at TPRE+1. Sensing starts at TPRE+TACT+1. The read word and rd_valid are due in cycle TPRE+TACT+TSENSE+1, and busy drops after cycle TPRE+TACT+TSENSE+1+TRESTORE; with the default parameters these are cycles 7 and 10. The bench model keeps one integer that counts cycles since accept and derives every expected strobe from it. It samples all outputs on the falling edge, half a period after the registers settle. Read data is compared only in the cycle where the model expects rd_valid.

// File: rtl/dram_bank_seq.sv
module dram_bank_seq #(
  parameter int ROWS     = 16,
  parameter int COLS     = 16,
  parameter int DW       = 8,
  parameter int TPRE     = 2,
  parameter int TACT     = 2,
  parameter int TSENSE   = 2,
  parameter int TRESTORE = 3,
  localparam int RAW  = $clog2(ROWS),
  localparam int CAW  = $clog2(COLS),
  localparam int AW   = (RAW > CAW) ? RAW : CAW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          row_stb,
  input  logic          col_stb,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          req_ready,
  output logic          busy,
  output logic          prech_en,
  output logic          wordline_en,
  output logic          sense_en,
  output logic          col_sel_en,
  output logic          restore_en,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam int TM01 = (TPRE > TACT) ? TPRE : TACT;
  localparam int TM23 = (TSENSE > TRESTORE) ? TSENSE : TRESTORE;
  localparam int TMAX = (TM01 > TM23) ? TM01 : TM23;
  localparam int CNTW = $clog2(TMAX + 1);
  localparam int RBW  = COLS * DW;

  typedef enum logic [2:0] {S_IDLE, S_ROWW, S_PRE, S_ACT, S_SENSE, S_COL, S_RST} st_t;

  st_t            st;
  logic [CNTW-1:0] cnt;
  logic [RAW-1:0] row_q;
  logic [CAW-1:0] col_q;
  logic           we_q;
  logic [DW-1:0]  wd_q;
  logic [RBW-1:0] rbuf;
  logic [RBW-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      row_q <= '0;
      col_q <= '0;
      we_q  <= 1'b0;
      wd_q  <= '0;
      rbuf  <= '0;
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else begin
      case (st)
        S_IDLE: if (row_stb) begin
          row_q <= addr[RAW-1:0];
          st    <= S_ROWW;
        end
        S_ROWW: if (col_stb) begin
          col_q <= addr[CAW-1:0];
          we_q  <= wr_en;
          wd_q  <= wr_data;
          cnt   <= CNTW'(TPRE - 1);
          st    <= S_PRE;
        end
        S_PRE: if (cnt == '0) begin
          cnt <= CNTW'(TACT - 1);
          st  <= S_ACT;
        end else cnt <= cnt - 1'b1;
        S_ACT: if (cnt == '0) begin
          rbuf       <= mem[row_q];
          mem[row_q] <= '0;
          cnt        <= CNTW'(TSENSE - 1);
          st         <= S_SENSE;
        end else cnt <= cnt - 1'b1;
        S_SENSE: if (cnt == '0) st <= S_COL;
        else cnt <= cnt - 1'b1;
        S_COL: begin
          if (we_q) rbuf[col_q*DW +: DW] <= wd_q;
          cnt <= CNTW'(TRESTORE - 1);
          st  <= S_RST;
        end
        S_RST: if (cnt == '0) begin
          mem[row_q] <= rbuf;
          st         <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st != S_IDLE) && (st != S_ROWW);
  assign req_ready   = !busy;
  assign prech_en    = (st == S_IDLE) || (st == S_ROWW) || (st == S_PRE);
  assign sense_en    = (st == S_SENSE) || (st == S_COL) || (st == S_RST);
  assign wordline_en = (st == S_ACT) || sense_en;
  assign col_sel_en  = (st == S_COL);
  assign restore_en  = (st == S_RST);
  assign rd_valid    = col_sel_en && !we_q;
  assign rd_data     = rbuf[col_q*DW +: DW];
endmodule

module dram_bank_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic prech_en,
  input logic wordline_en,
  input logic sense_en,
  input logic col_sel_en,
  input logic restore_en,
  input logic rd_valid
);
  a_r1_idle_precharged: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (prech_en && !wordline_en));
  a_r3_pre_excludes_wl: assert property (@(posedge clk) disable iff (!rst_n)
    !(prech_en && wordline_en));
  a_r4_sense_after_wl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sense_en) |-> $past(wordline_en));
  a_r4_sense_needs_wl: assert property (@(posedge clk) disable iff (!rst_n)
    sense_en |-> wordline_en);
  a_r5_col_while_sensed: assert property (@(posedge clk) disable iff (!rst_n)
    col_sel_en |-> (sense_en && wordline_en));
  a_r6_rdvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  a_r7_restore_after_col: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(col_sel_en) |-> restore_en);
  a_r9_busy_ends_in_restore: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(restore_en));
endmodule

bind dram_bank_seq dram_bank_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .prech_en(prech_en),
  .wordline_en(wordline_en), .sense_en(sense_en), .col_sel_en(col_sel_en),
  .restore_en(restore_en), .rd_valid(rd_valid)
);

// File: tb/dram_bank_seq_tb.sv
module dram_bank_seq_tb;
  localparam int ROWS = 16, COLS = 16, DW = 8;
  localparam int TPRE = 2, TACT = 2, TSENSE = 2, TRESTORE = 3;
  localparam int TOTAL = TPRE + TACT + TSENSE + 1 + TRESTORE;
  localparam int TCOL  = TPRE + TACT + TSENSE + 1;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic row_stb = 1'b0, col_stb = 1'b0, wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic req_ready, busy, prech_en, wordline_en, sense_en, col_sel_en, restore_en, rd_valid;
  logic [DW-1:0] rd_data;

  always #2.5 clk = ~clk;

  dram_bank_seq #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .TPRE(TPRE), .TACT(TACT),
                  .TSENSE(TSENSE), .TRESTORE(TRESTORE)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .row_stb(row_stb), .col_stb(col_stb),
    .wr_en(wr_en), .wr_data(wr_data), .req_ready(req_ready), .busy(busy),
    .prech_en(prech_en), .wordline_en(wordline_en), .sense_en(sense_en),
    .col_sel_en(col_sel_en), .restore_en(restore_en), .rd_valid(rd_valid),
    .rd_data(rd_data));

  int n_chk = 0, n_fail = 0, cyc = 0;
  int mm [ROWS][COLS];
  int m_t = 0, m_row = 0, m_col = 0, exp_rd = 0;
  bit m_pend = 0, m_we = 0;
  string rd_tag = "R6";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired (R9): actual busy %0d expected 0", busy);
      finish_run();
    end
    if (!rst_n) begin
      m_t = 0; m_pend = 0;
      for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) mm[r][c] = 0;
    end else if (m_t > 0) begin
      m_t = (m_t == TOTAL) ? 0 : m_t + 1;
    end else if (!m_pend && row_stb) begin
      m_row = int'(addr); m_pend = 1;
    end else if (m_pend && col_stb) begin
      m_col = int'(addr); m_we = wr_en; m_pend = 0; m_t = 1;
      exp_rd = mm[m_row][m_col];
      if (wr_en) mm[m_row][m_col] = int'(wr_data);
    end
  end

  always @(negedge clk) begin
    if (rst_n || cyc > 1) begin
      bit e_busy, e_pre, e_wl, e_sa, e_col, e_rst, e_rv;
      e_busy = (m_t != 0);
      e_pre  = (m_t == 0) || (m_t <= TPRE);
      e_wl   = (m_t > TPRE);
      e_sa   = (m_t > TPRE + TACT);
      e_col  = (m_t == TCOL);
      e_rst  = (m_t > TCOL);
      e_rv   = e_col && !m_we;
      chk(busy == e_busy,      "R9 busy",       busy, e_busy);
      chk(req_ready == !e_busy, "R9 req_ready", req_ready, !e_busy);
      chk(prech_en == e_pre,   "R3 prech_en",   prech_en, e_pre);
      chk(wordline_en == e_wl, "R4 wordline_en", wordline_en, e_wl);
      chk(sense_en == e_sa,    "R4 sense_en",   sense_en, e_sa);
      chk(col_sel_en == e_col, "R5 col_sel_en", col_sel_en, e_col);
      chk(restore_en == e_rst, "R7 restore_en", restore_en, e_rst);
      chk(rd_valid == e_rv,    "R6 rd_valid",   rd_valid, e_rv);
      if (e_rv) chk(int'(rd_data) == exp_rd, rd_tag, rd_data, exp_rd);
    end
  end

  task automatic access(input bit we, input int row, input int col, input int d, input string tag);
    rd_tag = tag;
    @(negedge clk); row_stb = 1; addr = AW'(row);
    @(negedge clk); row_stb = 0; col_stb = 1; addr = AW'(col); wr_en = we; wr_data = DW'(d);
    @(negedge clk); col_stb = 0; wr_en = 0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(prech_en && !wordline_en && !busy && req_ready, "R1 reset state", {prech_en, wordline_en, busy}, 3'b100);
    rst_n = 1;
    access(0, 3, 5, 0, "R1 memory zero after reset");
    access(1, 3, 5, 8'hA5, "R8");
    access(0, 3, 5, 0, "R6 read data");
    access(0, 3, 5, 0, "R7 reread after restore");
    access(0, 3, 4, 0, "R8 neighbour unchanged");
    access(1, 3, 4, 8'h3C, "R8");
    access(0, 3, 5, 0, "R8 first word kept");
    access(0, 3, 4, 0, "R6 second word");
    access(1, 15, 15, 8'hFF, "R8");
    access(1, 0, 0, 8'h01, "R8");
    access(0, 15, 15, 0, "R6 top corner");
    access(0, 0, 0, 0, "R6 bottom corner");
    access(0, 15, 0, 0, "R8 other column");
    // R2: lone column strobe ignored
    @(negedge clk); col_stb = 1; addr = 4'd7;
    @(negedge clk); @(negedge clk); col_stb = 0;
    chk(!busy, "R2 lone col_stb", busy, 0);
    // R2: second row strobe ignored
    access(1, 9, 5, 8'h77, "R2");
    access(1, 2, 5, 8'h22, "R2");
    rd_tag = "R2 second row strobe ignored";
    @(negedge clk); row_stb = 1; addr = 4'd2;
    @(negedge clk); addr = 4'd9;
    @(negedge clk); row_stb = 0; col_stb = 1; addr = 4'd5;
    @(negedge clk); col_stb = 0;
    while (busy) @(negedge clk);
    // R9: strobes while busy ignored
    rd_tag = "R9 strobes during busy";
    @(negedge clk); row_stb = 1; addr = 4'd9;
    @(negedge clk); row_stb = 0; col_stb = 1; addr = 4'd5;
    @(negedge clk); row_stb = 1; addr = 4'd2;
    repeat (3) @(negedge clk);
    row_stb = 0; col_stb = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(!busy, "R9 idle after ignored strobes", busy, 0);
    access(0, 9, 5, 0, "R9 row intact");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule